// File: doc/BRIEF.md
# Card Session Sequencer

This block runs one smart-card session at a time. It sits between a host controller and the card supply and contact drivers. It turns the step-up converter, card supply, contact I/O drivers, card clock and card reset on and off in a fixed timed order. Every step in that order is counted in half-steps of a base period. A free-running timebase supplies these half-steps as a one-cycle `tick` pulse. A base period of 25 µs gives a tick every 12.5 µs.

The host starts a session by pulling `start_n` low while `mode` is high. A session can also start when `mode` rises while `start_n` is already low. The session ends when `start_n` returns high or `mode` falls. Each end runs the same power-down order. If `mode` is low at the end of power-down, the block rests in low-power mode. During power-up there is a window in which raising `host_rst` starts the card clock early. Once the session is fully active, `host_rst` drives the card reset line only.

A card overcurrent, card removal or overheat stops the session at once and pulls the fault interrupt low. A low host supply also stops the session and raises `alarm`, but it leaves the fault interrupt untouched. After the supply recovers, `alarm` stays high for a retriggerable hold time. The card-side signals are plain control levels with no data path, so the block has no valid/ready interface and no back-pressure.

Top module: `card_session_seq`

## Requirements
- R1: After reset, every enable output is low, `card_rst` is low, `fault_n` is high, `alarm` is low and `low_power` is low. A session needs `start_n` to be seen high, or `mode` to be seen low, before it can start.
- R2: From idle, a session starts in the cycle after an edge at which all of the following hold: `mode` is high, `start_n` is low, the start is armed, `fault_n` is high, `alarm` is low and no card fault flag is set. This covers both a falling `start_n` and a rising `mode`. While `mode` is low, no session can start.
- R3: Power-up timeline, counted in ticks from session start:
  - `stepup_en` rises at the start.
  - `vcc_en` rises after 3 ticks.
  - `io_en` rises after 8 ticks.
  - `rst_en` rises after 14 ticks, and the session is then active.
- R4: While the power-up tick count is between 8 and 13, a high `host_rst` at a clock edge latches the card clock on, and `clk_en` rises in the following cycle. The clock is on throughout the active state. Once the session is active, `host_rst` has no effect on `clk_en`.
- R5: `card_rst` equals `host_rst` while `rst_en` is high, in the same cycle. Otherwise `card_rst` is low.
- R6: During power-up or the active state, any of these ends the session: `start_n` high, `mode` low, a card fault flag, or `supply_low`. Power-down timeline, counted in ticks from that point:
  - `rst_en` falls at once.
  - `clk_en` falls after 1 tick.
  - `io_en` falls after 2 ticks.
  - `vcc_en` falls after 3 ticks.
  - `stepup_en` falls after 10 ticks, and the block returns to idle.
- R7: If `mode` is low when power-down ends, or `mode` is low in idle, the block enters low-power mode (`low_power` high, all enables low). It returns to idle when `mode` is high.
- R8: A card fault flag (`flt_ovc`, `flt_gone` or `flt_hot`) seen during power-up or the active state drives `fault_n` low in the next cycle. `fault_n` returns high only at an edge where `start_n` is high and no card fault flag is set.
- R9: `supply_low` drives `alarm` high in the same cycle and never changes `fault_n`. After `supply_low` clears, `alarm` stays high for `HOLD_TICKS` further ticks. A new `supply_low` restarts that hold.
- R10: A start request made during power-down is acted on only once idle is reached. After a session has started, a new session needs `start_n` seen high, or `mode` seen low, in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every half base step |
| start_n | input | 1 | Active-low session request from host |
| mode | input | 1 | High = normal operation, low = low-power request |
| host_rst | input | 1 | Card reset request from host |
| flt_ovc | input | 1 | Card supply overcurrent flag |
| flt_gone | input | 1 | Card removed flag |
| flt_hot | input | 1 | Overtemperature flag |
| supply_low | input | 1 | Host supply below threshold |
| stepup_en | output | 1 | Step-up converter enable |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card I/O driver enable |
| clk_en | output | 1 | Card clock enable |
| rst_en | output | 1 | Card reset driver enable |
| card_rst | output | 1 | Card reset level |
| fault_n | output | 1 | Active-low fault interrupt |
| alarm | output | 1 | Supply alarm to host |
| low_power | output | 1 | Low-power mode indicator |

## Verification
All sequencing state lives in registers. A start or stop input seen at a clock edge therefore changes the enables in the cycle after that edge. A timeline step appears in the cycle after the tick edge that completes its count, and the same one-cycle delay applies to `fault_n` and the clock latch. `card_rst` and the rising edge of `alarm` follow their inputs in the same cycle. The bench drives inputs 2 ns after a rising edge and compares every output at the falling edge against a behavioural model. That model steps on the same edge, so each expected value lands in exactly the cycle described above.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_UP    = 3'd1,
    PH_ON    = 3'd2,
    PH_DOWN  = 3'd3,
    PH_SLEEP = 3'd4
  } phase_t;
endpackage

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
  import card_seq_pkg::*;
#(
  parameter int UP_DONE = 14,
  parameter int DN_DONE = 10,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start_n,
  input  logic          mode,
  input  logic          ready,
  input  logic          stop,
  output phase_t        phase,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] UP_LAST = CW'(UP_DONE - 1);
  localparam logic [CW-1:0] DN_LAST = CW'(DN_DONE - 1);

  logic armed;
  logic go;

  assign go = (phase == PH_IDLE) && mode && !start_n && armed && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (start_n || !mode) begin
      armed <= 1'b1;
    end else if (go) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (!mode)   phase <= PH_SLEEP;
          else if (go) phase <= PH_UP;
        end
        PH_UP: begin
          if (stop) begin
            phase <= PH_DOWN;
            cnt   <= '0;
          end else if (tick) begin
            if (cnt == UP_LAST) begin
              phase <= PH_ON;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_ON: begin
          if (stop) begin
            phase <= PH_DOWN;
            cnt   <= '0;
          end
        end
        PH_DOWN: begin
          if (tick) begin
            if (cnt == DN_LAST) begin
              phase <= mode ? PH_IDLE : PH_SLEEP;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        PH_SLEEP: begin
          cnt <= '0;
          if (mode) phase <= PH_IDLE;
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/card_clk_gate.sv
module card_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic window,
  input  logic force_on,
  input  logic host_rst,
  output logic run
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
    end else if (clear) begin
      run <= 1'b0;
    end else if ((window && host_rst) || force_on) begin
      run <= 1'b1;
    end
  end
endmodule

// File: rtl/card_alarm_hold.sv
module card_alarm_hold #(
  parameter int HOLD_TICKS = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_low,
  output logic alarm
);
  localparam int AW = $clog2(HOLD_TICKS + 1);
  localparam logic [AW-1:0] HOLD_LOAD = AW'(HOLD_TICKS);

  logic [AW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (supply_low) begin
      left <= HOLD_LOAD;
    end else if (tick && left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign alarm = supply_low || (left != '0);
endmodule

// File: rtl/card_fault_latch.sv
module card_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_session,
  input  logic card_flt,
  input  logic start_n,
  output logic fault_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_n <= 1'b1;
    end else if (card_flt && in_session) begin
      fault_n <= 1'b0;
    end else if (start_n && !card_flt) begin
      fault_n <= 1'b1;
    end
  end
endmodule

// File: rtl/card_session_seq.sv
module card_session_seq
  import card_seq_pkg::*;
#(
  parameter int UP_VCC_TK  = 3,
  parameter int UP_IO_TK   = 8,
  parameter int UP_DONE_TK = 14,
  parameter int DN_CLK_TK  = 1,
  parameter int DN_IO_TK   = 2,
  parameter int DN_VCC_TK  = 3,
  parameter int DN_DONE_TK = 10,
  parameter int HOLD_TICKS = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start_n,
  input  logic mode,
  input  logic host_rst,
  input  logic flt_ovc,
  input  logic flt_gone,
  input  logic flt_hot,
  input  logic supply_low,
  output logic stepup_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic rst_en,
  output logic card_rst,
  output logic fault_n,
  output logic alarm,
  output logic low_power
);
  localparam int MAXTK = (UP_DONE_TK > DN_DONE_TK) ? UP_DONE_TK : DN_DONE_TK;
  localparam int CW    = $clog2(MAXTK + 1);
  localparam logic [CW-1:0] K_UP_VCC = CW'(UP_VCC_TK);
  localparam logic [CW-1:0] K_UP_IO  = CW'(UP_IO_TK);
  localparam logic [CW-1:0] K_DN_CLK = CW'(DN_CLK_TK);
  localparam logic [CW-1:0] K_DN_IO  = CW'(DN_IO_TK);
  localparam logic [CW-1:0] K_DN_VCC = CW'(DN_VCC_TK);
  localparam logic [CW-1:0] K_DN_END = CW'(DN_DONE_TK);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          card_flt, stop, ready, clk_run;
  logic          ph_up, ph_on, ph_dn;

  assign card_flt = flt_ovc || flt_gone || flt_hot;
  assign stop     = start_n || !mode || card_flt || supply_low;
  assign ready    = fault_n && !alarm && !card_flt;

  card_seq_fsm #(
    .UP_DONE(UP_DONE_TK),
    .DN_DONE(DN_DONE_TK),
    .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_n(start_n), .mode(mode),
    .ready(ready), .stop(stop), .phase(phase), .cnt(cnt)
  );

  assign ph_up = (phase == PH_UP);
  assign ph_on = (phase == PH_ON);
  assign ph_dn = (phase == PH_DOWN);

  card_clk_gate u_clk (
    .clk(clk), .rst_n(rst_n),
    .clear(phase == PH_IDLE || phase == PH_SLEEP),
    .window(ph_up && cnt >= K_UP_IO),
    .force_on(ph_on),
    .host_rst(host_rst),
    .run(clk_run)
  );

  card_alarm_hold #(.HOLD_TICKS(HOLD_TICKS)) u_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low), .alarm(alarm)
  );

  card_fault_latch u_fault (
    .clk(clk), .rst_n(rst_n), .in_session(ph_up || ph_on),
    .card_flt(card_flt), .start_n(start_n), .fault_n(fault_n)
  );

  assign stepup_en = ph_up || ph_on || (ph_dn && cnt < K_DN_END);
  assign vcc_en    = (ph_up && cnt >= K_UP_VCC) || ph_on || (ph_dn && cnt < K_DN_VCC);
  assign io_en     = (ph_up && cnt >= K_UP_IO) || ph_on || (ph_dn && cnt < K_DN_IO);
  assign clk_en    = (ph_up && clk_run) || ph_on || (ph_dn && clk_run && cnt < K_DN_CLK);
  assign rst_en    = ph_on;
  assign card_rst  = ph_on && host_rst;
  assign low_power = (phase == PH_SLEEP);
endmodule

// File: rtl/card_session_seq_chk.sv
module card_session_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic start_n,
  input logic mode,
  input logic host_rst,
  input logic flt_ovc,
  input logic flt_gone,
  input logic flt_hot,
  input logic supply_low,
  input logic stepup_en,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic rst_en,
  input logic card_rst,
  input logic fault_n,
  input logic alarm,
  input logic low_power
);
  p_vcc_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> stepup_en);
  p_io_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);
  p_clk_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);
  p_rst_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (rst_en && host_rst));
  p_stop_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_en && start_n) |=> !rst_en);
  p_sleep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> !(stepup_en || vcc_en || io_en || clk_en || rst_en));
  p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flt_ovc || flt_gone || flt_hot) && rst_en) |=> !fault_n);
  p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_n && !(flt_ovc || flt_gone || flt_hot)) |=> fault_n);
  p_alarm_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> alarm);
  p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stepup_en && !mode) |=> !stepup_en);
  p_tick_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_en && !tick && !start_n && mode && !supply_low && !alarm) |=> vcc_en);
endmodule

bind card_session_seq card_session_seq_chk u_chk (.*);

// File: tb/card_session_seq_test.sv
module card_session_seq_test;
  localparam int TICK_DIV = 4;
  localparam int HOLD     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic start_n = 1'b1, mode = 1'b1, host_rst = 1'b0;
  logic flt_ovc = 1'b0, flt_gone = 1'b0, flt_hot = 1'b0, supply_low = 1'b0;
  logic stepup_en, vcc_en, io_en, clk_en, rst_en, card_rst, fault_n, alarm, low_power;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  card_session_seq #(.HOLD_TICKS(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_n(start_n), .mode(mode),
    .host_rst(host_rst), .flt_ovc(flt_ovc), .flt_gone(flt_gone), .flt_hot(flt_hot),
    .supply_low(supply_low), .stepup_en(stepup_en), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .rst_en(rst_en), .card_rst(card_rst), .fault_n(fault_n),
    .alarm(alarm), .low_power(low_power)
  );

  // timebase
  int tcnt = 0;
  always @(posedge clk) begin
    #2;
    tcnt = tcnt + 1;
    tick = (tcnt % TICK_DIV == 0);
  end

  // behavioural reference: 0 idle, 1 power-up, 2 active, 3 power-down, 4 low-power
  int m_ph = 0, m_t = 0, m_al = 0;
  bit m_clk = 0, m_flt = 1, m_arm = 0;

  always @(posedge clk) begin
    int o_ph, o_t;
    bit card, stop, al_on, go;
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_clk = 0; m_flt = 1; m_arm = 0; m_al = 0;
    end else begin
      o_ph  = m_ph;
      o_t   = m_t;
      card  = flt_ovc | flt_gone | flt_hot;
      stop  = start_n | !mode | card | supply_low;
      al_on = supply_low || (m_al > 0);
      go    = (o_ph == 0) && mode && !start_n && m_arm && m_flt && !al_on && !card;
      case (o_ph)
        0: if (!mode) m_ph = 4; else if (go) begin m_ph = 1; m_t = 0; end
        1: if (stop) begin m_ph = 3; m_t = 0; end
           else if (tick) begin
             if (o_t == 13) begin m_ph = 2; m_t = 0; end else m_t = o_t + 1;
           end
        2: if (stop) begin m_ph = 3; m_t = 0; end
        3: if (tick) begin
             if (o_t == 9) begin m_ph = mode ? 0 : 4; m_t = 0; end else m_t = o_t + 1;
           end
        default: if (mode) m_ph = 0;
      endcase
      if (o_ph == 0 || o_ph == 4) m_clk = 0;
      else if ((o_ph == 1 && o_t >= 8 && host_rst) || o_ph == 2) m_clk = 1;
      if (card && (o_ph == 1 || o_ph == 2)) m_flt = 0;
      else if (start_n && !card) m_flt = 1;
      if (start_n || !mode) m_arm = 1; else if (go) m_arm = 0;
      if (supply_low) m_al = HOLD; else if (tick && m_al > 0) m_al = m_al - 1;
    end
  end

  task automatic cmp(input string req, input string nm, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R3", "stepup_en", stepup_en, m_ph == 1 || m_ph == 2 || m_ph == 3);
      cmp("R3", "vcc_en", vcc_en, (m_ph == 1 && m_t >= 3) || m_ph == 2 || (m_ph == 3 && m_t < 3));
      cmp("R6", "io_en", io_en, (m_ph == 1 && m_t >= 8) || m_ph == 2 || (m_ph == 3 && m_t < 2));
      cmp("R4", "clk_en", clk_en, (m_ph == 1 && m_clk) || m_ph == 2 || (m_ph == 3 && m_clk && m_t < 1));
      cmp("R6", "rst_en", rst_en, m_ph == 2);
      cmp("R5", "card_rst", card_rst, m_ph == 2 && host_rst);
      cmp("R8", "fault_n", fault_n, m_flt);
      cmp("R9", "alarm", alarm, supply_low || m_al > 0);
      cmp("R7", "low_power", low_power, m_ph == 4);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails = fails + 1;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(5);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    cmp("R1", "stepup_en idle", stepup_en, 1'b0);
    cmp("R1", "fault_n idle", fault_n, 1'b1);
    cmp("R1", "alarm idle", alarm, 1'b0);

    // R2 R3 R4 R5: activation with early clock via host_rst
    start_n = 1'b0;
    step(1);
    cmp("R2", "stepup_en start", stepup_en, 1'b1);
    step(40);
    host_rst = 1'b1;
    step(30);
    cmp("R3", "rst_en active", rst_en, 1'b1);
    cmp("R5", "card_rst follows", card_rst, 1'b1);
    host_rst = 1'b0;
    #1;
    cmp("R5", "card_rst low", card_rst, 1'b0);
    step(3);
    cmp("R4", "clk_en unaffected", clk_en, 1'b1);
    start_n = 1'b1;
    step(60);
    cmp("R6", "stepup_en off", stepup_en, 1'b0);

    // R4: no host_rst, clock waits for active
    start_n = 1'b0;
    step(45);
    cmp("R4", "clk_en held off", clk_en, 1'b0);
    step(30);
    cmp("R4", "clk_en active", clk_en, 1'b1);

    // R7: mode low -> power-down -> low-power; mode rise restarts
    mode = 1'b0;
    step(60);
    cmp("R7", "low_power", low_power, 1'b1);
    step(20);
    cmp("R7", "no start asleep", stepup_en, 1'b0);
    mode = 1'b1;
    step(5);
    cmp("R2", "mode-rise start", stepup_en, 1'b1);

    // R8 R10: card removal while active
    step(80);
    flt_gone = 1'b1;
    step(2);
    cmp("R8", "fault_n set", fault_n, 1'b0);
    flt_gone = 1'b0;
    step(80);
    cmp("R10", "no restart unarmed", stepup_en, 1'b0);
    cmp("R8", "fault_n held", fault_n, 1'b0);
    start_n = 1'b1;
    step(2);
    cmp("R8", "fault_n cleared", fault_n, 1'b1);

    // R10: request during power-down waits for idle
    start_n = 1'b0;
    step(80);
    start_n = 1'b1;
    step(8);
    start_n = 1'b0;
    step(10);
    cmp("R10", "still powering down", vcc_en, 1'b0);
    step(40);
    step(20);
    cmp("R10", "restart after idle", stepup_en, 1'b1);

    // R8: overheat during power-up, flag held while start_n high
    start_n = 1'b1;
    step(60);
    start_n = 1'b0;
    step(10);
    flt_hot = 1'b1;
    step(2);
    cmp("R8", "fault_n on hot", fault_n, 1'b0);
    start_n = 1'b1;
    step(60);
    cmp("R8", "fault_n flag held", fault_n, 1'b0);
    flt_hot = 1'b0;
    step(2);
    cmp("R8", "fault_n released", fault_n, 1'b1);

    // R9: supply low
    start_n = 1'b0;
    step(80);
    supply_low = 1'b1;
    #1;
    cmp("R9", "alarm immediate", alarm, 1'b1);
    step(2);
    cmp("R9", "fault_n untouched", fault_n, 1'b1);
    step(60);
    cmp("R9", "session stopped", stepup_en, 1'b0);
    supply_low = 1'b0;
    step(10);
    cmp("R9", "alarm held", alarm, 1'b1);
    supply_low = 1'b1;
    step(1);
    supply_low = 1'b0;
    start_n = 1'b1;
    step(2);
    start_n = 1'b0;
    step(16);
    cmp("R9", "retriggered hold", alarm, 1'b1);
    cmp("R9", "start blocked by alarm", stepup_en, 1'b0);
    step(30);
    cmp("R9", "alarm expired", alarm, 1'b0);
    cmp("R2", "start after alarm", stepup_en, 1'b1);
    start_n = 1'b1;
    step(60);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule